// File: doc/BRIEF.md
# Posted Write Target with Outstanding Address Queue

This block is the write side of a memory-mapped target. It takes write requests over three independent valid/ready channels, in the style of the AXI4 write path. The address channel carries a transaction tag, a start address and a burst length. The data channel carries beats with byte strobes and an end-of-burst marker but no tag. The response channel returns one tagged status per transaction. A master may post several addresses, and stream their data, before the first response comes back. The block keeps those addresses in a queue and applies each data burst to the oldest address that has not yet received data.

Each beat writes into a small internal byte-addressable array. Beat addresses advance by the bus width from the start address, and the low address bits below the bus width are ignored. A beat whose address falls beyond the array is dropped, and its transaction is answered with an error status. A combinational read port on the array lets the neighbouring read-side logic see the stored words.

Top module: `posted_write_target`

## Requirements
- R1: `awready` is high exactly when the address queue holds fewer than `AQ_DEPTH` (default 4) accepted but unfinished writes, so up to `AQ_DEPTH` addresses are taken before any data or response.
- R2: `wready` is low while no accepted address is waiting for data, and also while the response queue is full (`BQ_DEPTH` entries, default 4).
- R3: Data bursts are applied to addresses in acceptance order; beat k of a burst targets byte address start + k*(DATA_W/8), with address bits below the bus width ignored, and stored word index = byte address / (DATA_W/8).
- R4: Exactly one response is produced per transaction, queued in the cycle its beat with `wlast`=1 is accepted, so `bvalid` rises no earlier than the cycle after that beat.
- R5: Responses leave in transaction order and each `bid` equals the `awid` of its transaction.
- R6: Strobe bit i of `wstrb` enables the update of data bits [8i+7:8i] of the addressed word; bytes whose strobe is 0 keep their previous value.
- R7: A beat whose byte address is at or above `MEM_WORDS`*(DATA_W/8) (default 256) writes nothing, and its transaction's `bresp` is 2'b10 (error); a transaction whose beats are all in range gets `bresp` 2'b00 (okay).
- R8: While `bvalid` is high and `bready` is low, `bvalid`, `bid` and `bresp` stay unchanged.
- R9: After a synchronous active-low reset, `awready` is 1, `wready` is 0 and `bvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address accepted when high with awvalid |
| awaddr | input | ADDR_W | Burst start byte address |
| awid | input | ID_W | Transaction tag |
| awlen | input | LEN_W | Beats in burst minus one |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data accepted when high with wvalid |
| wdata | input | DATA_W | Beat data |
| wstrb | input | DATA_W/8 | Byte enables of the beat |
| wlast | input | 1 | Final beat of the burst |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response taken when high with bvalid |
| bid | output | ID_W | Tag of the finished transaction |
| bresp | output | 2 | Status: 2'b00 okay, 2'b10 error |
| rd_idx | input | $clog2(MEM_WORDS) | Word index for the storage read port |
| rd_data | output | DATA_W | Stored word at rd_idx |

## Verification
The assertions assume that the master marks with `wlast` precisely beat number `awlen` of each burst and never sends data for more bursts than addresses it has posted, and that it keeps the response channel unblocked in the long run. The bench builds every burst from the same length it places on the address channel, sending data in the order the addresses are issued, so the end marker always agrees with the posted length. It holds `bready` low for long stretches to fill the response queue, and otherwise keeps all valids legal: once raised, a valid stays high with its payload unchanged until it is taken.

// File: rtl/pwt_pkg.sv
// Shared definitions for the posted write target.
// Assumes: response codes follow the common two-bit write status encoding.
package pwt_pkg;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

endpackage

// File: rtl/pwt_fifo.sv
// Synchronous first-in first-out queue with full and empty flags.
// Assumes: the user never pushes while full nor pops while empty;
// storage is not reset, only pointers and the fill count are.
module pwt_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full  = (count == FULL_C);
    assign empty = (count == '0);
    assign dout  = slots[rd_ptr];

    // Store the incoming entry at the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    // R1: the upstream ready gating must prevent a push into a full queue.
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R5: the downstream handshake must never pop an empty queue.
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/pwt_store.sv
// Byte-lane storage array with one strobed write port and one
// combinational read port.
// Assumes: widx and ridx are below WORDS; contents are not reset.
module pwt_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] widx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W/8-1:0]      wstrb,
    input  logic [$clog2(WORDS)-1:0] ridx,
    output logic [DATA_W-1:0]        rdata
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        // Update this byte lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (we && wstrb[g]) lane_mem[widx] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = lane_mem[ridx];
    end

endmodule

// File: rtl/posted_write_target.sv
// Write target accepting several posted write addresses ahead of their
// data and responses. Data bursts carry no tag, so each one is bound to
// the oldest queued address; one tagged response follows each burst.
// Assumes: wlast marks exactly beat awlen of each burst; ADDR_W+1 bits
// can hold MEM_WORDS*(DATA_W/8); DATA_W is a power-of-two multiple of 8.
module posted_write_target #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 4,
    parameter int LEN_W     = 8,
    parameter int AQ_DEPTH  = 4,
    parameter int BQ_DEPTH  = 4,
    parameter int MEM_WORDS = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         awvalid,
    output logic                         awready,
    input  logic [ADDR_W-1:0]            awaddr,
    input  logic [ID_W-1:0]              awid,
    input  logic [LEN_W-1:0]             awlen,
    input  logic                         wvalid,
    output logic                         wready,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [DATA_W/8-1:0]          wstrb,
    input  logic                         wlast,
    output logic                         bvalid,
    input  logic                         bready,
    output logic [ID_W-1:0]              bid,
    output logic [1:0]                   bresp,
    input  logic [$clog2(MEM_WORDS)-1:0] rd_idx,
    output logic [DATA_W-1:0]            rd_data
);
    import pwt_pkg::*;

    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);
    localparam int IDX_W = $clog2(MEM_WORDS);
    localparam int AQ_W  = ID_W + ADDR_W + LEN_W;
    localparam int BQ_W  = ID_W + 2;
    localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W + 1)'(MEM_WORDS * BYTES);
    localparam logic [ADDR_W:0] STEP_V  = (ADDR_W + 1)'(BYTES);

    // Address queue
    logic            aq_push, aq_pop, aq_full, aq_empty;
    logic [AQ_W-1:0] aq_dout;
    logic [ID_W-1:0]   hd_id;
    logic [ADDR_W-1:0] hd_addr;
    logic [LEN_W-1:0]  hd_len;

    assign awready = !aq_full;
    assign aq_push = awvalid && awready;

    pwt_fifo #(.WIDTH(AQ_W), .DEPTH(AQ_DEPTH)) u_addr_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (aq_push),
        .din   ({awid, awaddr, awlen}),
        .full  (aq_full),
        .pop   (aq_pop),
        .dout  (aq_dout),
        .empty (aq_empty)
    );

    assign hd_len  = aq_dout[0 +: LEN_W];
    assign hd_addr = aq_dout[LEN_W +: ADDR_W];
    assign hd_id   = aq_dout[LEN_W + ADDR_W +: ID_W];

    // Burst walker
    logic              bq_full, bq_empty, bq_push, bq_pop;
    logic [BQ_W-1:0]   bq_dout;
    logic              w_hs, first_beat, beat_ok;
    logic [LEN_W-1:0]  beat_cnt;
    logic [ADDR_W:0]   cur_addr, beat_addr;
    logic              burst_err;
    resp_e             done_resp;

    assign wready     = !aq_empty && !bq_full;
    assign w_hs       = wvalid && wready;
    assign first_beat = (beat_cnt == '0);
    assign beat_addr  = first_beat ? {1'b0, hd_addr} : cur_addr;
    assign beat_ok    = (beat_addr < LIMIT_V);
    assign aq_pop     = w_hs && wlast;
    assign bq_push    = w_hs && wlast;
    assign done_resp  = (burst_err || !beat_ok) ? RESP_SLVERR : RESP_OKAY;

    // Track beat position, next beat address and error within a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt  <= '0;
            cur_addr  <= '0;
            burst_err <= 1'b0;
        end else if (w_hs) begin
            cur_addr <= beat_addr + STEP_V;
            if (wlast) begin
                beat_cnt  <= '0;
                burst_err <= 1'b0;
            end else begin
                beat_cnt  <= beat_cnt + 1'b1;
                burst_err <= burst_err || !beat_ok;
            end
        end
    end

    pwt_store #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_store (
        .clk   (clk),
        .we    (w_hs && beat_ok),
        .widx  (beat_addr[OFF_W +: IDX_W]),
        .wdata (wdata),
        .wstrb (wstrb),
        .ridx  (rd_idx),
        .rdata (rd_data)
    );

    // Response queue
    assign bq_pop = bvalid && bready;

    pwt_fifo #(.WIDTH(BQ_W), .DEPTH(BQ_DEPTH)) u_resp_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (bq_push),
        .din   ({hd_id, done_resp}),
        .full  (bq_full),
        .pop   (bq_pop),
        .dout  (bq_dout),
        .empty (bq_empty)
    );

    assign bvalid = !bq_empty;
    assign bid    = bq_dout[2 +: ID_W];
    assign bresp  = bq_dout[1:0];

    // R4: the end marker must land on the beat the posted length names.
    a_r4_last_on_len: assert property (@(posedge clk) disable iff (!rst_n)
        w_hs |-> (wlast == (beat_cnt == hd_len)));

    // R4: a response only appears after a finishing beat was taken.
    a_r4_resp_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bvalid) |-> $past(w_hs && wlast));

    // R8: a stalled response keeps its valid, tag and status.
    a_r8_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bid) && $stable(bresp)));

endmodule

// File: tb/posted_write_target_tb.sv
module posted_write_target_tb;
    localparam int ADDR_W = 12, DATA_W = 32, ID_W = 4, LEN_W = 8;
    localparam int AQD = 4, BQD = 4, WORDS = 64, NB = 4;
    localparam int LIMIT = WORDS * NB;

    logic clk = 1'b0, rst_n = 1'b0;
    logic awvalid = 0, wvalid = 0, wlast = 0, bready = 0;
    logic awready, wready, bvalid;
    logic [ADDR_W-1:0] awaddr = '0;
    logic [ID_W-1:0]   awid = '0, bid;
    logic [LEN_W-1:0]  awlen = '0;
    logic [DATA_W-1:0] wdata = '0, rd_data;
    logic [NB-1:0]     wstrb = '0;
    logic [1:0]        bresp;
    logic [5:0]        rd_idx = '0;

    always #2 clk = ~clk;

    posted_write_target u_dut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awid(awid), .awlen(awlen),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bid(bid), .bresp(bresp),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // Behavioural reference model
    int m_aid[$], m_aaddr[$], m_alen[$], m_bid[$], m_bresp[$];
    int m_beat = 0, m_cur = 0, m_bdone = 0;
    bit m_err = 0;
    logic [7:0] ref_mem [LIMIT];
    bit ref_known [LIMIT];

    function automatic bit x_awready(); return m_aid.size() < AQD; endfunction
    function automatic bit x_wready();  return m_aid.size() > 0 && m_bid.size() < BQD; endfunction
    function automatic bit x_bvalid();  return m_bid.size() > 0; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_aid.delete(); m_aaddr.delete(); m_alen.delete();
            m_bid.delete(); m_bresp.delete();
            m_beat = 0; m_cur = 0; m_err = 0;
        end else begin
            bit aw_hs, w_hs, b_hs;
            aw_hs = awvalid && x_awready();
            w_hs  = wvalid && x_wready();
            b_hs  = bready && x_bvalid();
            if (b_hs) begin
                void'(m_bid.pop_front()); void'(m_bresp.pop_front());
                m_bdone++;
            end
            if (w_hs) begin
                int a;
                bit ok;
                a  = (m_beat == 0) ? m_aaddr[0] : m_cur;
                ok = a < LIMIT;
                if (ok) for (int i = 0; i < NB; i++)
                    if (wstrb[i]) begin
                        ref_mem[(a / NB) * NB + i] = wdata[8*i +: 8];
                        ref_known[(a / NB) * NB + i] = 1;
                    end
                m_err = m_err || !ok;
                if (wlast) begin
                    m_bid.push_back(m_aid[0]);
                    m_bresp.push_back(m_err ? 2 : 0);
                    void'(m_aid.pop_front()); void'(m_aaddr.pop_front()); void'(m_alen.pop_front());
                    m_beat = 0; m_err = 0;
                end else begin
                    m_beat++;
                    m_cur = a + NB;
                end
            end
            if (aw_hs) begin
                m_aid.push_back(int'(awid)); m_aaddr.push_back(int'(awaddr)); m_alen.push_back(int'(awlen));
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare registered outputs with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(awready == x_awready(), "R1 awready", awready, x_awready());
            chk(wready == x_wready(), "R2 wready", wready, x_wready());
            chk(bvalid == x_bvalid(), "R4 bvalid", bvalid, x_bvalid());
            if (bvalid && x_bvalid()) begin
                chk(int'(bid) == m_bid[0], "R5/R8 bid", bid, m_bid[0]);
                chk(int'(bresp) == m_bresp[0], "R7/R8 bresp", bresp, m_bresp[0]);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Batch description
    int t_id[64], t_addr[64], t_len[64];
    int nt = 0;

    task automatic run_batch(input int wdelay, input int bhold, input bit rnd);
        int target;
        target = m_bdone + nt;
        fork
            begin : aw_side
                for (int t = 0; t < nt; t++) begin
                    bit r;
                    if (rnd) repeat ($urandom_range(0, 2)) @(negedge clk);
                    awvalid = 1; awid = ID_W'(t_id[t]); awaddr = ADDR_W'(t_addr[t]); awlen = LEN_W'(t_len[t]);
                    forever begin r = awready; @(negedge clk); if (r) break; end
                    awvalid = 0;
                end
            end
            begin : w_side
                repeat (wdelay) @(negedge clk);
                for (int t = 0; t < nt; t++)
                    for (int b = 0; b <= t_len[t]; b++) begin
                        bit r;
                        if (rnd) repeat ($urandom_range(0, 1)) @(negedge clk);
                        wvalid = 1; wdata = $urandom; wlast = (b == t_len[t]);
                        wstrb = rnd ? NB'($urandom) : '1;
                        forever begin r = wready; @(negedge clk); if (r) break; end
                        wvalid = 0; wlast = 0;
                    end
            end
            begin : b_side
                int k;
                k = 0;
                while (m_bdone < target) begin
                    bready = (k < bhold) ? 1'b0 : (rnd ? 1'($urandom) : 1'b1);
                    k++;
                    @(negedge clk);
                end
                bready = 0;
            end
        join
    endtask

    initial begin
        for (int i = 0; i < LIMIT; i++) ref_known[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(awready == 1'b1, "R9 reset awready", awready, 1);
        chk(wready == 1'b0, "R9 reset wready", wready, 0);
        chk(bvalid == 1'b0, "R9 reset bvalid", bvalid, 0);
        rst_n = 1;
        @(negedge clk);

        // R1/R2: five posted addresses, data held back, responses blocked.
        nt = 5;
        t_id[0] = 1; t_addr[0] = 0;  t_len[0] = 1;
        t_id[1] = 2; t_addr[1] = 16; t_len[1] = 0;
        t_id[2] = 3; t_addr[2] = 32; t_len[2] = 3;
        t_id[3] = 4; t_addr[3] = 48; t_len[3] = 2;
        t_id[4] = 5; t_addr[4] = 66; t_len[4] = 0;
        run_batch(20, 60, 0);

        // R7: burst crossing the array end, fully outside, and in range.
        nt = 3;
        t_id[0] = 7; t_addr[0] = 248;  t_len[0] = 2;
        t_id[1] = 8; t_addr[1] = 1000; t_len[1] = 0;
        t_id[2] = 9; t_addr[2] = 100;  t_len[2] = 0;
        run_batch(0, 0, 0);

        // R3/R5/R6: random tags, addresses, lengths, strobes and gaps.
        nt = 40;
        for (int t = 0; t < nt; t++) begin
            t_id[t] = $urandom_range(0, 15);
            t_addr[t] = $urandom_range(0, 299);
            t_len[t] = $urandom_range(0, 3);
        end
        run_batch(3, 8, 1);
        repeat (4) @(negedge clk);

        // R3/R6/R7: stored contents against the model.
        for (int w = 0; w < WORDS; w++) begin
            logic [DATA_W-1:0] m, e;
            rd_idx = 6'(w);
            #1;
            m = '0; e = '0;
            for (int i = 0; i < NB; i++)
                if (ref_known[w*NB+i]) begin m[8*i +: 8] = 8'hFF; e[8*i +: 8] = ref_mem[w*NB+i]; end
            chk((rd_data & m) == e, "R3/R6 stored word", int'(rd_data & m), int'(e));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule